// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Strobe Generator

This block keeps an asynchronous DRAM array alive by paced row refreshes. A free-running interval timer produces one refresh request every `INTERVAL` clocks. The interval is derived from the retention period, the row count and the clock period, so that every row is refreshed once per period. Requests go into a bounded backlog. The block asks the access controller for the bus with `ref_req`. Once the controller answers with `ref_gnt`, the block owns the strobes until the row precharge is finished.

Two refresh styles are supported and chosen per refresh at grant time. The first is a CAS-before-RAS cycle, in which the memory's own row counter picks the row and the write strobe is held high so the cycle cannot be taken as a test-mode entry. The second is a row-address-only cycle. In that style the block drives the row from its own counter and pulses RAS while CAS stays high. After reset, a fixed number of CAS-before-RAS cycles are forced to initialise the memory, whatever style is selected.

While the backlog is full, or during initialisation, `ref_urgent` tells the controller that refresh must win over host accesses. Every strobe and status output is driven from a flop or decoded only from registered state, so no input reaches an output combinationally.

Top module: `dram_refresh_sched`

## Requirements
- R1: After synchronous reset, `ras_n`, `cas_n` and `we_n` are 1, `busy` and `ref_ack` are 0, `init_done` is 0, and `ref_req` and `ref_urgent` are 1 because initialisation is pending.
- R2: A refresh tick occurs every INTERVAL = floor(REF_PERIOD_NS / (CLK_PERIOD_NS * ROWS)) clocks, counted from reset release. With an empty backlog, successive rises of `ref_req` are exactly INTERVAL clocks apart.
- R3: The first INIT_CBR refreshes after reset are CAS-before-RAS, whatever the value of `mode_row_only`. `ref_urgent` stays 1 until they are done, and `init_done` becomes 1 in the cycle `ref_ack` of the last one is high.
- R4: A CAS-before-RAS refresh runs in this order. First comes one busy cycle with all strobes high. Then `cas_n` is 0 for T_CSR cycles with `ras_n` high. Then `ras_n` is 0 for T_RAS cycles, with `cas_n` still 0 only for the first T_CHR of them. `we_n` is 1 throughout.
- R5: A row-address-only refresh (`mode_row_only` = 1 at grant, initialisation done) keeps `cas_n` at 1. After one setup cycle, `ras_n` is 0 for T_RAS cycles, and `addr` carries the row for the whole busy period.
- R6: Every refresh ends with `ras_n` high for T_RP cycles before `busy` falls. `busy` is 1 from the cycle after grant through the end of precharge: 1+T_CSR+T_RAS+T_RP cycles for CAS-before-RAS and 1+T_RAS+T_RP for row-address-only. `ref_ack` is a one-cycle pulse in the first cycle with `busy` at 0.
- R7: The row counter starts at 0. It advances by one after each row-address-only refresh, wraps from ROWS-1 to 0, and is left unchanged by CAS-before-RAS refreshes.
- R8: Each tick adds one to the backlog, which saturates at MAX_PEND, so further ticks are dropped. `ref_urgent` is 1 exactly while the backlog holds MAX_PEND. Each completed refresh removes one entry.
- R9: `ref_gnt` starts a refresh only in a cycle where `ref_req` is 1. `mode_row_only` is sampled only at that grant. Changes to `ref_gnt` or `mode_row_only` while `busy` is 1 have no effect on the strobes.
- R10: `ref_req` is 0 while `busy` is 1 and whenever nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_row_only | input | 1 | Refresh style at grant: 0 CAS-before-RAS, 1 row-address-only |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh wanted, block idle |
| ref_urgent | output | 1 | Backlog full or initialisation pending: refresh has priority |
| ref_ack | output | 1 | One-cycle pulse when a refresh has completed |
| busy | output | 1 | Block owns the DRAM strobes |
| init_done | output | 1 | Initialisation refreshes completed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr | output | ROW_W | Row address for row-address-only refresh |

## Verification
The bench goes after the ordering of the two strobes. A design that lowered RAS first, or released CAS too early, would turn a CAS-before-RAS cycle into a plain access. It also targets the style choice during initialisation and at the grant edge: a design that looked at the mode pin while busy, or skipped the forced initial cycles, would emit the wrong strobe pattern. It fills the backlog past its limit and then counts the refreshes drained, so a counter that wraps or fails to saturate gives the wrong count. Finally it runs more row-address-only refreshes than there are rows, which catches a row counter that fails to wrap to 0 or that advances on CAS-before-RAS cycles.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_CAS_LEAD,
    SQ_ACTIVE,
    SQ_PRECH
  } seq_state_e;

  typedef enum logic {
    STYLE_CBR = 1'b0,
    STYLE_ROW = 1'b1
  } ref_style_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/refsched_pacer.sv
module refsched_pacer #(
  parameter int INTERVAL = 781
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R2: ticks are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
  parameter int MAX_PEND = 8,
  parameter int INIT_CBR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fin,
  output logic pending,
  output logic urgent,
  output logic init_active
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int IW = $clog2(INIT_CBR + 2);
  localparam logic [PW-1:0] PMAX  = PW'(MAX_PEND);
  localparam logic [IW-1:0] ILOAD = IW'(INIT_CBR);

  logic [PW-1:0] pend;
  logic [IW-1:0] init_left;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      init_left <= ILOAD;
    end else if (init_left != '0) begin
      if (fin) init_left <= init_left - 1'b1;
      if (tick && pend != PMAX) pend <= pend + 1'b1;
    end else begin
      case ({tick, fin})
        2'b10:   if (pend != PMAX) pend <= pend + 1'b1;
        2'b01:   if (pend != '0) pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign init_active = (init_left != '0);
  assign pending     = init_active || (pend != '0);
  assign urgent      = init_active || (pend == PMAX);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R8: backlog never exceeds its limit
  a_r8_pend_cap: assert property (@(posedge clk) disable iff (rst)
    pend <= PMAX);
  // R8: backlog moves by at most one per cycle
  a_r8_pend_step: assert property (@(posedge clk) disable iff (rst)
    (armed && pend != $past(pend)) |->
      (pend == $past(pend) + 1'b1 || pend + 1'b1 == $past(pend)));
  // R3: initialisation count never grows after reset
  a_r3_init_monotone: assert property (@(posedge clk) disable iff (rst)
    armed |-> init_left <= $past(init_left));

endmodule

// File: rtl/refsched_rowctr.sv
module refsched_rowctr #(
  parameter int ROWS = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_nx;
  logic             armed;

  generate
    if ((1 << ROW_W) == ROWS) begin : g_pow2
      assign row_nx = row_q + 1'b1;
    end else begin : g_any
      assign row_nx = (row_q == LAST) ? '0 : row_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else if (step) row_q <= row_nx;
  end

  assign row = row_q;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R7: last row wraps to zero
  a_r7_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(step) && $past(row_q) == LAST) |-> row_q == '0);
  // R7: no step, no change
  a_r7_row_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(step)) |-> $stable(row_q));

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
  import dram_refresh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 3,
  parameter int T_RP  = 3,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  ref_style_e       style,
  input  logic [ROW_W-1:0] row_in,
  output logic             idle,
  output logic             fin,
  output ref_style_e       cur_style,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic             busy,
  output logic             ack
);
  localparam int TMAX = max3(T_CSR, T_RAS, T_RP);
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CSR_LAST = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_LIM  = CW'(T_CHR);

  seq_state_e state, nxt_state;
  logic [CW-1:0] cnt, nxt_cnt;
  ref_style_e ror_q, nxt_ror;
  logic armed;

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    nxt_ror   = ror_q;
    fin       = 1'b0;
    case (state)
      SQ_IDLE: if (start) begin
        nxt_state = SQ_SETUP;
        nxt_cnt   = '0;
        nxt_ror   = style;
      end
      SQ_SETUP: begin
        nxt_state = (ror_q == STYLE_ROW) ? SQ_ACTIVE : SQ_CAS_LEAD;
        nxt_cnt   = '0;
      end
      SQ_CAS_LEAD: if (cnt == CSR_LAST) begin
        nxt_state = SQ_ACTIVE;
        nxt_cnt   = '0;
      end else nxt_cnt = cnt + 1'b1;
      SQ_ACTIVE: if (cnt == RAS_LAST) begin
        nxt_state = SQ_PRECH;
        nxt_cnt   = '0;
      end else nxt_cnt = cnt + 1'b1;
      SQ_PRECH: if (cnt == RP_LAST) begin
        nxt_state = SQ_IDLE;
        nxt_cnt   = '0;
        fin       = 1'b1;
      end else nxt_cnt = cnt + 1'b1;
      default: nxt_state = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      ror_q <= STYLE_CBR;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      busy  <= 1'b0;
      ack   <= 1'b0;
      addr  <= '0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
      ror_q <= nxt_ror;
      ras_n <= !(nxt_state == SQ_ACTIVE);
      cas_n <= !(nxt_state == SQ_CAS_LEAD ||
                 (nxt_state == SQ_ACTIVE && nxt_ror == STYLE_CBR && nxt_cnt < CHR_LIM));
      we_n  <= 1'b1;
      busy  <= (nxt_state != SQ_IDLE);
      ack   <= fin;
      if (state == SQ_IDLE && start) addr <= row_in;
    end
  end

  assign idle      = (state == SQ_IDLE);
  assign cur_style = ror_q;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R4: RAS only falls in CBR style while CAS is already low
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(ras_n) && ror_q == STYLE_CBR) |-> !$past(cas_n));
  // R5: row-address-only style never lowers CAS
  a_r5_ror_cas_high: assert property (@(posedge clk) disable iff (rst)
    (busy && ror_q == STYLE_ROW) |-> cas_n);
  // R6: acknowledge is a single pulse outside the busy window
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |-> (!busy ##1 !ack));
  // R9: style is frozen for the whole refresh
  a_r9_style_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && busy && $past(busy)) |-> $stable(ror_q));
  // R4: write strobe stays high during a refresh
  a_r4_we_high: assert property (@(posedge clk) disable iff (rst)
    busy |-> we_n);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int REF_PERIOD_NS = 16_000_000,
  parameter int ROWS          = 1024,
  parameter int MAX_PEND      = 8,
  parameter int INIT_CBR      = 8,
  parameter int T_CSR         = 1,
  parameter int T_CHR         = 1,
  parameter int T_RAS         = 3,
  parameter int T_RP          = 3,
  localparam int ROW_W        = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_row_only,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             ref_ack,
  output logic             busy,
  output logic             init_done,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);
  localparam int INTERVAL = REF_PERIOD_NS / (CLK_PERIOD_NS * ROWS);

  logic             tick;
  logic             pending;
  logic             init_active;
  logic             seq_idle;
  logic             seq_fin;
  ref_style_e       seq_style;
  ref_style_e       pick_style;
  logic [ROW_W-1:0] row;
  logic             start;

  refsched_pacer #(.INTERVAL(INTERVAL)) pacer_i (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  refsched_backlog #(.MAX_PEND(MAX_PEND), .INIT_CBR(INIT_CBR)) backlog_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .fin        (seq_fin),
    .pending    (pending),
    .urgent     (ref_urgent),
    .init_active(init_active)
  );

  refsched_rowctr #(.ROWS(ROWS)) rowctr_i (
    .clk (clk),
    .rst (rst),
    .step(seq_fin && seq_style == STYLE_ROW),
    .row (row)
  );

  assign ref_req    = seq_idle && pending;
  assign start      = ref_req && ref_gnt;
  assign pick_style = init_active ? STYLE_CBR : ref_style_e'(mode_row_only);
  assign init_done  = !init_active;

  refsched_seq #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .ROW_W(ROW_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .style    (pick_style),
    .row_in   (row),
    .idle     (seq_idle),
    .fin      (seq_fin),
    .cur_style(seq_style),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .busy     (busy),
    .ack      (ref_ack)
  );

  // R10: no request while the strobes are owned
  a_r10_no_req_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ref_req);
  // R3: urgency is held throughout initialisation
  a_r3_init_urgent: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> ref_urgent);

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int CLK_NS  = 20;
  localparam int ROWS    = 1024;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int INT_CYC = 80;
  localparam int REF_NS  = INT_CYC * CLK_NS * ROWS;
  localparam int MAXP    = 8;
  localparam int INITN   = 8;
  localparam int TCSR = 1, TCHR = 1, TRAS = 3, TRP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_row_only = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, ref_ack, busy, init_done, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] addr;

  dram_refresh_sched #(
    .CLK_PERIOD_NS(CLK_NS), .REF_PERIOD_NS(REF_NS), .ROWS(ROWS),
    .MAX_PEND(MAXP), .INIT_CBR(INITN),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) dut_i (
    .clk(clk), .rst(rst), .mode_row_only(mode_row_only), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_ack(ref_ack), .busy(busy),
    .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic bit exp_ras(input bit ror, input int k);
    int s;
    s = ror ? 1 : 1 + TCSR;
    return !(k >= s && k < s + TRAS);
  endfunction

  function automatic bit exp_cas(input bit ror, input int k);
    if (ror) return 1'b1;
    return !(k >= 1 && k < 1 + TCSR + TCHR);
  endfunction

  function automatic int seq_len(input bit ror);
    return 1 + (ror ? 0 : TCSR) + TRAS + TRP;
  endfunction

  // monitor state
  bit prev_busy = 1'b0;
  int k = 0;
  bit cur_ror = 1'b0;
  int row_exp = 0;
  int init_exp = INITN;
  int pat_err = 0, addr_err = 0, req_err = 0;
  int ror_done = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_busy = 1'b0;
    end else begin
      if (busy) begin
        k = prev_busy ? k + 1 : 0;
        if (ras_n !== exp_ras(cur_ror, k) || cas_n !== exp_cas(cur_ror, k) ||
            we_n !== 1'b1 || ref_ack !== 1'b0) pat_err++;
        if (cur_ror && addr !== ROW_W'(row_exp)) addr_err++;
        if (ref_req !== 1'b0) req_err++;
      end else if (prev_busy) begin
        // R4 (CBR) or R5 (row-only) strobe pattern, R6 length and ack
        check(pat_err == 0, cur_ror ? "R5 pattern" : "R4 pattern", pat_err, 0);
        check(k + 1 == seq_len(cur_ror), "R6 busy length", k + 1, seq_len(cur_ror));
        check(ref_ack === 1'b1, "R6 ack pulse", int'(ref_ack), 1);
        check(req_err == 0, "R10 req during busy", req_err, 0);
        if (cur_ror) begin
          check(addr_err == 0, "R7 row address", int'(addr), row_exp);
          row_exp = (row_exp + 1) % ROWS;
          ror_done++;
        end
        if (init_exp > 0) init_exp--;
        pat_err = 0; addr_err = 0; req_err = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic grant_one(input bit m, input int hold);
    while (ref_req !== 1'b1) step();
    mode_row_only = m;
    cur_ror = m && (init_exp == 0);
    ref_gnt = 1'b1;
    for (int h = 0; h < hold; h++) begin
      step();
      mode_row_only = 1'($urandom);   // R9: ignored while busy
    end
    ref_gnt = 1'b0;
    while (busy === 1'b1) begin
      step();
      mode_row_only = 1'($urandom);
    end
  endtask

  initial begin
    #(190000 * CLK_NS);
    check(1'b0, "watchdog", cyc, 0);
    finish_up();
  end

  initial begin
    int t0, t1, n;
    void'($urandom(32'd4242));
    repeat (4) step();
    rst = 1'b0;
    step();

    // R1 reset state
    check(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R1 strobes idle",
          int'({ras_n, cas_n, we_n}), 7);
    check(busy === 1'b0 && ref_ack === 1'b0, "R1 busy/ack low", int'({busy, ref_ack}), 0);
    check(init_done === 1'b0, "R1 init_done low", int'(init_done), 0);
    check(ref_req === 1'b1 && ref_urgent === 1'b1, "R1 req/urgent high",
          int'({ref_req, ref_urgent}), 3);

    // R3 initialisation: row-only requested, CBR expected
    for (int i = 0; i < INITN; i++) begin
      check(ref_urgent === 1'b1, "R3 urgent during init", int'(ref_urgent), 1);
      grant_one(1'b1, 1);
      check(init_done === (i == INITN - 1), "R3 init_done timing", int'(init_done),
            int'(i == INITN - 1));
    end
    check(ref_urgent === 1'b0, "R3 urgent released", int'(ref_urgent), 0);

    while (ref_req === 1'b1) grant_one(1'($urandom), 1);

    // R9 grant with no request is ignored
    ref_gnt = 1'b1;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (busy !== 1'b0) n++;
    end
    ref_gnt = 1'b0;
    check(n == 0, "R9 grant without request", n, 0);
    check(ref_req === 1'b0, "R10 no request when empty", int'(ref_req), 0);

    // R2 interval
    while (ref_req !== 1'b1) step();
    t0 = cyc;
    grant_one(1'b0, 1);
    while (ref_req !== 1'b1) step();
    t1 = cyc;
    check(t1 - t0 == INT_CYC, "R2 tick interval", t1 - t0, INT_CYC);
    grant_one(1'b1, 1);

    // R8 backlog saturation
    while (ref_req !== 1'b1) step();
    t0 = cyc;
    while (ref_urgent !== 1'b1) step();
    t1 = cyc;
    check(t1 - t0 == (MAXP - 1) * INT_CYC, "R8 urgent at full", t1 - t0, (MAXP - 1) * INT_CYC);
    repeat (3 * INT_CYC) step();
    check(ref_urgent === 1'b1, "R8 urgent held while full", int'(ref_urgent), 1);
    n = 0;
    while (ref_req === 1'b1) begin
      grant_one(1'b1, 1);
      n++;
      if (n == 1) check(ref_urgent === 1'b0, "R8 urgent drops after one", int'(ref_urgent), 0);
    end
    check(n == MAXP, "R8 drained count", n, MAXP);

    // random mix: style, grant delay, grant hold
    for (int i = 0; i < 40; i++) begin
      repeat ($urandom % 30) step();
      if (ref_req === 1'b1) grant_one(1'($urandom), 1 + int'($urandom % 3));
    end

    // R7 wrap: more row-only refreshes than rows
    while (ror_done < ROWS + 4) grant_one(1'b1, 1);
    check(ror_done > ROWS, "R7 wrap exercised", ror_done, ROWS + 4);
    check(row_exp == (ror_done % ROWS), "R7 counter model", row_exp, ror_done % ROWS);

    repeat (4) step();
    finish_up();
  end

endmodule